// File: doc/BRIEF.md
# Programmable Step Counter

A synchronous N-bit counter that advances by a fixed step on every enabled clock edge. It runs in one of two modes, chosen by a parameter. In free-running mode the value wraps modulo 2^N. The count moves up, moves down, or follows a direction input. A load strobe can replace the count with a data word. In bounded mode the counter starts at an initial value and steps toward a terminal value. On the cycle after it reaches that value it restarts from the initial value.

The output can be read as unsigned or as two's complement; the arithmetic is identical bit for bit. Setting a flag makes the terminal value the largest number the chosen width and signedness can hold. Bad parameter combinations stop elaboration.

Each cycle a decoder picks one operation from a small enumerated set: `OP_CLEAR` (reset), `OP_HOLD` (enable low), `OP_LOAD` (load a data word, free-running only), `OP_RESTART` (terminal value reached, bounded only), `OP_ADD` and `OP_SUB`. Priority runs in that order, with add versus subtract chosen last. The count register then takes the value that the operation yields.

Top module: `step_counter`

## Requirements
- R1: When `rst` is 1 at a clock edge, `count` becomes `INIT_VAL` (truncated to `WIDTH` bits), whatever `en`, `load` or `up_dn` are.
- R2: When `rst` is 0 and `en` is 0, `count` keeps its value across the edge, and `load`, `din` and `up_dn` have no effect.
- R3: In free-running up mode (`DIR` = `DIR_UP`), an enabled edge without load gives `count + STEP` modulo 2^WIDTH, and `up_dn` is ignored.
- R4: In free-running down mode (`DIR` = `DIR_DOWN`), an enabled edge without load gives `count - STEP` modulo 2^WIDTH, and `up_dn` is ignored.
- R5: With `DIR` = `DIR_UPDOWN`, an enabled step adds `STEP` when `up_dn` is 1 and subtracts it when `up_dn` is 0.
- R6: In free-running mode, `en`=1 with `load`=1 makes `count` equal `din` after the edge, which takes priority over stepping.
- R7: In bounded mode (`LIMITED`=1), an enabled edge with `count` equal to the terminal value gives `INIT_VAL`; otherwise it steps as in R3/R4/R5.
- R8: In bounded up/down mode, reaching the terminal value restarts from `INIT_VAL` whichever way the counter was moving.
- R9: In bounded mode, `load` and `din` are ignored.
- R10: With `END_IS_MAX`=1 the terminal value is 2^WIDTH-1 for unsigned output and 2^(WIDTH-1)-1 for signed output.
- R11: With signed output, stepping up from the most positive value wraps to the most negative value, and stepping down reverses it (two's complement at `WIDTH` bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to the initial value, active high |
| en | input | 1 | Count enable, active high |
| up_dn | input | 1 | Direction in up/down mode: 1 adds, 0 subtracts |
| load | input | 1 | Load strobe, used only in free-running mode |
| din | input | WIDTH | Word to load |
| count | output | WIDTH | Current count |

## Verification
The bench runs five 4-bit instances side by side on shared inputs, which makes every value of each counter reachable within a few thousand cycles:
- a bounded up/down unsigned counter (start 2, end 14, step 3). Counting down it wraps past zero before it meets the terminal value.
- free-running up and down unsigned counters with steps 3 and 5, which wrap at 16.
- a signed free-running up/down counter starting at +7, which shows the wrap between +7 and -8.
- a signed bounded up counter with the maximum terminal value, which restarts from -5 after reaching +7.

Random reset, enable, load and direction patterns then cross every operation against an arithmetic model.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        DIR_UP     = 2'd0,
        DIR_DOWN   = 2'd1,
        DIR_UPDOWN = 2'd2
    } ctr_dir_e;

    typedef enum logic [2:0] {
        OP_CLEAR   = 3'd0,
        OP_HOLD    = 3'd1,
        OP_LOAD    = 3'd2,
        OP_RESTART = 3'd3,
        OP_ADD     = 3'd4,
        OP_SUB     = 3'd5
    } ctr_op_e;

endpackage

// File: rtl/ctr_op_sel.sv
module ctr_op_sel
    import ctr_pkg::*;
#(
    parameter bit       LIMITED = 1'b0,
    parameter ctr_dir_e DIR     = DIR_UP
) (
    input  logic    rst,
    input  logic    en,
    input  logic    up_dn,
    input  logic    load,
    input  logic    at_end,
    output ctr_op_e op
);

    localparam bit LOAD_OK = !LIMITED;

    logic go_up;

    always_comb begin
        unique case (DIR)
            DIR_UP:     go_up = 1'b1;
            DIR_DOWN:   go_up = 1'b0;
            default:    go_up = up_dn;
        endcase
    end

    always_comb begin
        if (rst)
            op = OP_CLEAR;
        else if (!en)
            op = OP_HOLD;
        else if (LOAD_OK && load)
            op = OP_LOAD;
        else if (at_end)
            op = OP_RESTART;
        else if (go_up)
            op = OP_ADD;
        else
            op = OP_SUB;
    end

endmodule

// File: rtl/ctr_end_cmp.sv
module ctr_end_cmp #(
    parameter int               WIDTH   = 8,
    parameter bit               LIMITED = 1'b0,
    parameter logic [WIDTH-1:0] TERM    = '0
) (
    input  logic [WIDTH-1:0] count,
    output logic             at_end
);

    // Equality is the same for signed and unsigned readings of the bits.
    assign at_end = LIMITED && (count == TERM);

endmodule

// File: rtl/ctr_step_unit.sv
module ctr_step_unit
    import ctr_pkg::*;
#(
    parameter int               WIDTH  = 8,
    parameter logic [WIDTH-1:0] START  = '0,
    parameter logic [WIDTH-1:0] STRIDE = '0
) (
    input  ctr_op_e          op,
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);

    always_comb begin
        unique case (op)
            OP_CLEAR,
            OP_RESTART: nxt = START;
            OP_HOLD:    nxt = count;
            OP_LOAD:    nxt = din;
            OP_ADD:     nxt = count + STRIDE;
            OP_SUB:     nxt = count - STRIDE;
            default:    nxt = count;
        endcase
    end

endmodule

// File: rtl/step_counter.sv
module step_counter
    import ctr_pkg::*;
#(
    parameter int       WIDTH      = 8,
    parameter bit       IS_SIGNED  = 1'b0,
    parameter bit       LIMITED    = 1'b0,
    parameter ctr_dir_e DIR        = DIR_UP,
    parameter longint   INIT_VAL   = 0,
    parameter longint   END_VAL    = 255,
    parameter bit       END_IS_MAX = 1'b0,
    parameter longint   STEP       = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             up_dn,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] MAX_W    = IS_SIGNED ? (ALL_ONES >> 1) : ALL_ONES;
    localparam logic [WIDTH-1:0] INIT_W   = WIDTH'(INIT_VAL);
    localparam logic [WIDTH-1:0] END_W    = END_IS_MAX ? MAX_W : WIDTH'(END_VAL);
    localparam logic [WIDTH-1:0] STEP_W   = WIDTH'(STEP);

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_nxt;
    logic             at_end;
    ctr_op_e          op;

    ctr_end_cmp #(
        .WIDTH   (WIDTH),
        .LIMITED (LIMITED),
        .TERM    (END_W)
    ) u_end_cmp (
        .count  (count_q),
        .at_end (at_end)
    );

    ctr_op_sel #(
        .LIMITED (LIMITED),
        .DIR     (DIR)
    ) u_op_sel (
        .rst    (rst),
        .en     (en),
        .up_dn  (up_dn),
        .load   (load),
        .at_end (at_end),
        .op     (op)
    );

    ctr_step_unit #(
        .WIDTH  (WIDTH),
        .START  (INIT_W),
        .STRIDE (STEP_W)
    ) u_step (
        .op    (op),
        .count (count_q),
        .din   (din),
        .nxt   (count_nxt)
    );

    // Count register; reset arrives as OP_CLEAR through the decoder.
    always_ff @(posedge clk) begin
        count_q <= count_nxt;
    end

    always_comb begin
        count = count_q;
    end

endmodule

// File: rtl/step_counter_chk.sv
module step_counter_chk
    import ctr_pkg::*;
#(
    parameter int       WIDTH      = 8,
    parameter bit       IS_SIGNED  = 1'b0,
    parameter bit       LIMITED    = 1'b0,
    parameter ctr_dir_e DIR        = DIR_UP,
    parameter longint   INIT_VAL   = 0,
    parameter longint   END_VAL    = 255,
    parameter bit       END_IS_MAX = 1'b0,
    parameter longint   STEP       = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             up_dn,
    input logic             load,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] MAX_W    = IS_SIGNED ? (ALL_ONES >> 1) : ALL_ONES;
    localparam logic [WIDTH-1:0] INIT_W   = WIDTH'(INIT_VAL);
    localparam logic [WIDTH-1:0] END_W    = END_IS_MAX ? MAX_W : WIDTH'(END_VAL);
    localparam logic [WIDTH-1:0] STEP_W   = WIDTH'(STEP);
    localparam logic [WIDTH-1:0] SPAN_W   = END_W - INIT_W;

    // Parameter legality, stopped at elaboration.
    if (STEP_W == '0) begin : g_bad_step
        $error("step_counter: step must be nonzero");
    end
    if (LIMITED && WIDTH > 64) begin : g_bad_width
        $error("step_counter: bounded mode allows at most 64 bits");
    end
    if (LIMITED && END_W == INIT_W) begin : g_bad_end
        $error("step_counter: terminal value equals initial value");
    end
    if (LIMITED && STEP_W != '0 && (SPAN_W % STEP_W) != '0) begin : g_bad_span
        $error("step_counter: step does not divide the counting span");
    end

    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    AST_RESET_INIT: assert property (@(posedge clk)
        rst |=> count == INIT_W); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst || !armed)
        !en |=> $stable(count)); // R2

    if (!LIMITED) begin : g_free
        AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst || !armed)
            en && load |=> count == $past(din)); // R6

        if (DIR == DIR_UP) begin : g_up
            AST_FREE_UP: assert property (@(posedge clk) disable iff (rst || !armed)
                en && !load |=> count == WIDTH'($past(count) + STEP_W)); // R3
        end else if (DIR == DIR_DOWN) begin : g_dn
            AST_FREE_DOWN: assert property (@(posedge clk) disable iff (rst || !armed)
                en && !load |=> count == WIDTH'($past(count) - STEP_W)); // R4
        end else begin : g_ud
            AST_DIR_ADD: assert property (@(posedge clk) disable iff (rst || !armed)
                en && !load && up_dn |=> count == WIDTH'($past(count) + STEP_W)); // R5
            AST_DIR_SUB: assert property (@(posedge clk) disable iff (rst || !armed)
                en && !load && !up_dn |=> count == WIDTH'($past(count) - STEP_W)); // R5
        end
    end else begin : g_lim
        AST_TERM_RESTART: assert property (@(posedge clk) disable iff (rst || !armed)
            en && count == END_W |=> count == INIT_W); // R7

        if (DIR == DIR_UPDOWN) begin : g_ud
            AST_LIM_DOWN_STEP: assert property (@(posedge clk) disable iff (rst || !armed)
                en && count != END_W && !up_dn |=> count == WIDTH'($past(count) - STEP_W)); // R8
            AST_LIM_UP_STEP: assert property (@(posedge clk) disable iff (rst || !armed)
                en && count != END_W && up_dn |=> count == WIDTH'($past(count) + STEP_W)); // R9
        end else if (DIR == DIR_UP) begin : g_up
            AST_LIM_UP_ONLY: assert property (@(posedge clk) disable iff (rst || !armed)
                en && count != END_W |=> count == WIDTH'($past(count) + STEP_W)); // R9
            if (END_IS_MAX) begin : g_max
                AST_MAX_RESTART: assert property (@(posedge clk) disable iff (rst || !armed)
                    en && count == MAX_W |=> count == INIT_W); // R10
            end
        end else begin : g_dn
            AST_LIM_DOWN_ONLY: assert property (@(posedge clk) disable iff (rst || !armed)
                en && count != END_W |=> count == WIDTH'($past(count) - STEP_W)); // R9
        end
    end

    if (IS_SIGNED && !LIMITED && DIR != DIR_DOWN) begin : g_sgn
        AST_SIGNED_WRAP: assert property (@(posedge clk) disable iff (rst || !armed)
            en && !load && (DIR == DIR_UP || up_dn) && STEP_W == 1 && count == MAX_W
            |=> count == ~MAX_W); // R11
    end

endmodule

bind step_counter step_counter_chk #(
    .WIDTH      (WIDTH),
    .IS_SIGNED  (IS_SIGNED),
    .LIMITED    (LIMITED),
    .DIR        (DIR),
    .INIT_VAL   (INIT_VAL),
    .END_VAL    (END_VAL),
    .END_IS_MAX (END_IS_MAX),
    .STEP       (STEP)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .up_dn (up_dn),
    .load  (load),
    .din   (din),
    .count (count)
);

// File: tb/step_counter_tb_top.sv
module step_counter_tb_top;
    import ctr_pkg::*;

    localparam int HALF = 4; // 125 MHz

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       up_dn = 1'b0;
    logic       load = 1'b0;
    logic [3:0] din = 4'h0;
    logic       checking = 1'b0;
    int         n_tests = 0;
    int         n_fail = 0;

    logic [3:0] cnt [5];
    logic [3:0] exp_v [5];
    string      tg_v [5];

    // Per-instance model settings: bounded, direction (0 up, 1 down, 2 up/down),
    // initial, terminal, step, tag for a plain step.
    bit         c_lim  [5] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
    int         c_dir  [5] = '{2, 0, 1, 2, 0};
    logic [3:0] c_init [5] = '{4'd2, 4'd0, 4'd1, 4'd7, 4'hB};
    logic [3:0] c_end  [5] = '{4'd14, 4'd0, 4'd0, 4'd0, 4'd7};
    logic [3:0] c_stp  [5] = '{4'd3, 4'd3, 4'd5, 4'd1, 4'd4};
    string      c_tag  [5] = '{"R8", "R3", "R4", "R5", "R10"};

    always #HALF clk = ~clk;

    step_counter #(.WIDTH(4), .IS_SIGNED(1'b0), .LIMITED(1'b1), .DIR(DIR_UPDOWN),
                   .INIT_VAL(2), .END_VAL(14), .END_IS_MAX(1'b0), .STEP(3))
        dut_i (.clk(clk), .rst(rst), .en(en), .up_dn(up_dn), .load(load), .din(din), .count(cnt[0]));

    step_counter #(.WIDTH(4), .IS_SIGNED(1'b0), .LIMITED(1'b0), .DIR(DIR_UP),
                   .INIT_VAL(0), .END_VAL(0), .END_IS_MAX(1'b0), .STEP(3))
        dut_up_i (.clk(clk), .rst(rst), .en(en), .up_dn(up_dn), .load(load), .din(din), .count(cnt[1]));

    step_counter #(.WIDTH(4), .IS_SIGNED(1'b0), .LIMITED(1'b0), .DIR(DIR_DOWN),
                   .INIT_VAL(1), .END_VAL(0), .END_IS_MAX(1'b0), .STEP(5))
        dut_dn_i (.clk(clk), .rst(rst), .en(en), .up_dn(up_dn), .load(load), .din(din), .count(cnt[2]));

    step_counter #(.WIDTH(4), .IS_SIGNED(1'b1), .LIMITED(1'b0), .DIR(DIR_UPDOWN),
                   .INIT_VAL(7), .END_VAL(0), .END_IS_MAX(1'b0), .STEP(1))
        dut_ud_i (.clk(clk), .rst(rst), .en(en), .up_dn(up_dn), .load(load), .din(din), .count(cnt[3]));

    step_counter #(.WIDTH(4), .IS_SIGNED(1'b1), .LIMITED(1'b1), .DIR(DIR_UP),
                   .INIT_VAL(-5), .END_VAL(0), .END_IS_MAX(1'b1), .STEP(4))
        dut_max_i (.clk(clk), .rst(rst), .en(en), .up_dn(up_dn), .load(load), .din(din), .count(cnt[4]));

    function automatic logic [3:0] model_next(input int k, input logic [3:0] cur,
                                              input logic r, input logic e, input logic d,
                                              input logic ld, input logic [3:0] di);
        bit add;
        if (r) return c_init[k];                            // R1
        if (!e) return cur;                                 // R2
        if (!c_lim[k] && ld) return di;                     // R6
        if (c_lim[k] && cur == c_end[k]) return c_init[k];  // R7
        add = (c_dir[k] == 0) || (c_dir[k] == 2 && d);
        return add ? cur + c_stp[k] : cur - c_stp[k];
    endfunction

    function automatic string model_tag(input int k, input logic [3:0] cur,
                                        input logic r, input logic e, input logic ld);
        if (r) return "R1";
        if (!e) return "R2";
        if (!c_lim[k] && ld) return "R6";
        if (c_lim[k] && cur == c_end[k]) return (c_dir[k] == 2) ? "R8" : "R7";
        if (c_lim[k] && ld) return "R9";
        return c_tag[k];
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 5; k++) begin
            tg_v[k]  <= model_tag(k, exp_v[k], rst, en, load);
            exp_v[k] <= model_next(k, exp_v[k], rst, en, up_dn, load, din);
        end
    end

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            for (int k = 0; k < 5; k++) check(tg_v[k], cnt[k], exp_v[k]);
        end
    end

    task automatic drive(input logic r, input logic e, input logic d,
                         input logic ld, input logic [3:0] di);
        @(negedge clk);
        rst = r; en = e; up_dn = d; load = ld; din = di;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        after_edge();
        after_edge();
        checking = 1'b1;

        // R1: reset wins over disabled enable and a pending load
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'h9);
        after_edge();
        for (int k = 0; k < 5; k++) check("R1", cnt[k], c_init[k]);

        // R11 and R10 directed walk
        drive(1'b0, 1'b1, 1'b1, 1'b0, 4'h0);
        after_edge();
        check("R11", cnt[3], 4'h8);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
        after_edge();
        check("R11", cnt[3], 4'h7);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 4'h0);
        after_edge();
        check("R10", cnt[4], 4'h7);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 4'h0);
        after_edge();
        check("R10", cnt[4], 4'hB);

        // R9: load on the bounded counter leaves its sequence intact
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'hD);
        after_edge();
        check("R6", cnt[1], 4'hD);

        for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, 1'b1, 1'b0, 4'h0);
        for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 50) == 0, ($urandom % 4) != 0, 1'($urandom % 2),
                  ($urandom % 6) == 0, 4'($urandom));
        end
        drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
        after_edge();
        @(negedge clk);
        checking = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(2 * HALF * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule